// File: doc/BRIEF.md
# Triplexed LCD Drive Sequencer

This block produces the time-multiplexed drive codes for a liquid crystal panel that has three common (row) lines. Each segment line crosses all three commons and so carries three segments. The panel is driven at one-third duty and one-third bias. A prescaler divides the system clock down to a phase tick. A sequencer steps through six phases per frame. Each common is active twice in every frame, and the second visit has the opposite polarity, so the waveform seen by any segment averages to zero.

Every output is a 2-bit level code. An analog stage outside this block turns each code into one of four voltages taken from a ladder of three equal resistors. The codes are: 0 = top rail, 1 = one third down, 2 = two thirds down, 3 = full drive below the top rail.

The segment pattern is copied into a shadow register only at frame boundaries, so a single frame never shows a mix of old and new data. The shutdown input freezes the sequencer and drives every output to the top-rail code.

Top module: `lcd_tri_drive`

## Requirements
- R1: While reset is held, the outputs show phase 0 with all segments off: common 1 = 0, commons 2 and 3 = 2, every segment line = 1, whatever the value of seg_i.
- R2: The phases run 0,1,2,3,4,5 and then wrap to 0. Each phase lasts exactly PHASE_DIV clock cycles. The active common is common ((phase mod 3)+1).
- R3: In phases 0 to 2 the active common drives 0 and the inactive commons drive 2. In phases 3 to 5 the active common drives 3 and the inactive commons drive 1. com_o[2c+1:2c] is common c+1.
- R4: A segment line drives 3 in phases 0 to 2 when its segment on the active common is ON, and 1 when it is OFF. In phases 3 to 5 it drives 0 when ON and 2 when OFF.
- R5: seg_i[3k+c] is the ON bit of segment line k on common c+1. seg_o[2k+1:2k] is the level code of segment line k.
- R6: seg_i is sampled only at the clock edge that moves phase 5 to phase 0. A change in the middle of a frame has no effect until the next phase 0.
- R7: While shutdown_i is high, every common and segment output is 0 in the same cycle, and the prescaler and sequencer are held.
- R8: When shutdown_i falls, the outputs resume at phase 0 using the seg_i value present during shutdown, and that phase lasts the full PHASE_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shutdown_i | input | 1 | Stops sequencing and drives all outputs to the top-rail code |
| seg_i | input | 3*N_LINES | Segment ON bits, three per segment line |
| com_o | output | 6 | Level codes of the three commons |
| seg_o | output | 2*N_LINES | Level codes of the segment lines |

## Verification
The assertions assume that shutdown_i and seg_i are synchronous to clk_i, and that shutdown_i combines with the outputs without any added latency. The bench changes inputs only at falling edges, so that every input is stable at the rising edge that samples it. It finds frame boundaries from the common codes themselves, rather than counting cycles from reset. New patterns are applied well before the boundary that is meant to load them, and the mid-frame change lands in phase 2 so that its effect on R6 is unambiguous.

// File: rtl/lcd_tri_pkg.sv
package lcd_tri_pkg;
  typedef enum logic [1:0] {
    LVL_TOP = 2'd0,
    LVL_HI  = 2'd1,
    LVL_LO  = 2'd2,
    LVL_BOT = 2'd3
  } lvl_e;

  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned NUM_COMS   = 3;
  localparam int unsigned PW         = $clog2(NUM_PHASES);

  typedef logic [PW-1:0] phase_t;
endpackage

// File: rtl/lcd_prescale.sv
module lcd_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (halt_i)           cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !halt_i;

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < int'(DIV));
  a_r7_halt_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (cnt_q == '0));
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_tri_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       tick_i,
  output logic [1:0] act_o,
  output logic       neg_o,
  output logic       wrap_o
);
  localparam phase_t LAST_PH = phase_t'(NUM_PHASES - 1);
  localparam phase_t HALF_PH = phase_t'(NUM_COMS);

  phase_t phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       phase_q <= '0;
    else if (halt_i)                   phase_q <= '0;
    else if (tick_i && phase_q == LAST_PH) phase_q <= '0;
    else if (tick_i)                   phase_q <= phase_q + 1'b1;
  end

  assign neg_o  = (phase_q >= HALF_PH);
  assign act_o  = neg_o ? 2'(phase_q - HALF_PH) : 2'(phase_q);
  assign wrap_o = tick_i && (phase_q == LAST_PH);

  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST_PH);
  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i) |=> phase_q == (($past(phase_q) == LAST_PH) ? phase_t'(0) : $past(phase_q) + 1'b1));
  a_r2_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !halt_i) |=> $stable(phase_q));
endmodule

// File: rtl/lcd_com_line.sv
module lcd_com_line
  import lcd_tri_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic [1:0] act_i,
  input  logic       neg_i,
  input  logic       shut_i,
  output logic [1:0] lvl_o
);
  lvl_e lvl;

  always_comb begin
    if (shut_i)                    lvl = LVL_TOP;
    else if (act_i == 2'(IDX))     lvl = neg_i ? LVL_BOT : LVL_TOP;
    else                           lvl = neg_i ? LVL_HI  : LVL_LO;
  end

  assign lvl_o = lvl;
endmodule

// File: rtl/lcd_seg_line.sv
module lcd_seg_line
  import lcd_tri_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] on_i,
  input  logic [1:0] act_i,
  input  logic       neg_i,
  input  logic       shut_i,
  output logic [1:0] lvl_o
);
  lvl_e lvl;
  logic sel_on;

  assign sel_on = on_i[act_i];

  always_comb begin
    if (shut_i)       lvl = LVL_TOP;
    else if (neg_i)   lvl = sel_on ? LVL_TOP : LVL_LO;
    else              lvl = sel_on ? LVL_BOT : LVL_HI;
  end

  assign lvl_o = lvl;

  // segment always stays on the side away from the active common
  a_r4_side_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shut_i && !neg_i) |-> (lvl_o == 2'd1 || lvl_o == 2'd3));
  a_r4_side_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shut_i && neg_i) |-> (lvl_o == 2'd0 || lvl_o == 2'd2));
endmodule

// File: rtl/lcd_tri_drive.sv
module lcd_tri_drive
  import lcd_tri_pkg::*;
#(
  parameter int unsigned N_LINES   = 4,
  parameter int unsigned PHASE_DIV = 92593
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shutdown_i,
  input  logic [3*N_LINES-1:0]   seg_i,
  output logic [2*NUM_COMS-1:0]  com_o,
  output logic [2*N_LINES-1:0]   seg_o
);
  localparam int unsigned SW = NUM_COMS * N_LINES;

  logic          tick;
  logic          wrap;
  logic [1:0]    act;
  logic          neg;
  logic [SW-1:0] shadow_q;
  logic [NUM_COMS-1:0] com_ext;

  lcd_prescale #(.DIV(PHASE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (shutdown_i),
    .tick_o (tick)
  );

  lcd_phase_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (shutdown_i),
    .tick_i (tick),
    .act_o  (act),
    .neg_o  (neg),
    .wrap_o (wrap)
  );

  // pattern only moves at frame boundary; tracks input while shut down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  shadow_q <= '0;
    else if (wrap || shutdown_i)  shadow_q <= seg_i;
  end

  for (genvar c = 0; c < NUM_COMS; c++) begin : g_com
    lcd_com_line #(.IDX(c)) u_com (
      .act_i  (act),
      .neg_i  (neg),
      .shut_i (shutdown_i),
      .lvl_o  (com_o[2*c +: 2])
    );
    assign com_ext[c] = (com_o[2*c +: 2] == 2'd0) || (com_o[2*c +: 2] == 2'd3);
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_seg
    lcd_seg_line u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .on_i   (shadow_q[3*k +: 3]),
      .act_i  (act),
      .neg_i  (neg),
      .shut_i (shutdown_i),
      .lvl_o  (seg_o[2*k +: 2])
    );
  end

  a_r3_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutdown_i |-> $onehot(com_ext));
  a_r6_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap && !shutdown_i) |=> $stable(shadow_q));
  a_r7_shutdown_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |-> (com_o == '0 && seg_o == '0));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutdown_i) |-> (com_o[1:0] == 2'd0));
endmodule

// File: tb/lcd_tri_drive_tb.sv
`timescale 1ns/1ps
module lcd_tri_drive_tb;
  localparam int NL  = 4;
  localparam int DIV = 4;
  localparam int NV  = 6;
  localparam logic [3*NL-1:0] PATS [NV] = '{
    12'h000, 12'hFFF, 12'h249, 12'h492, 12'h924, 12'hA5C
  };

  logic clk = 0;
  logic rst_n = 0;
  logic shut = 0;
  logic [3*NL-1:0] seg_in = '1;
  logic [5:0] com;
  logic [2*NL-1:0] seg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_tri_drive #(.N_LINES(NL), .PHASE_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shutdown_i(shut),
    .seg_i(seg_in), .com_o(com), .seg_o(seg)
  );

  function automatic logic [5:0] exp_com(int p);
    logic [5:0] r;
    for (int c = 0; c < 3; c++) begin
      if (c == p % 3) r[2*c +: 2] = (p >= 3) ? 2'd3 : 2'd0;
      else            r[2*c +: 2] = (p >= 3) ? 2'd1 : 2'd2;
    end
    return r;
  endfunction

  function automatic logic [2*NL-1:0] exp_seg(logic [3*NL-1:0] pat, int p);
    logic [2*NL-1:0] r;
    for (int k = 0; k < NL; k++) begin
      if (pat[3*k + p % 3]) r[2*k +: 2] = (p >= 3) ? 2'd0 : 2'd3;
      else                  r[2*k +: 2] = (p >= 3) ? 2'd2 : 2'd1;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // wait for phase 5 then phase 0, land on the first sample of phase 0
  task automatic sync_frame();
    bit seen5 = 0;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (com == exp_com(5)) seen5 = 1;
      else if (seen5 && com == exp_com(0)) return;
    end
    chk("R2 sync", 0, 1);
  endtask

  // check one whole frame starting at first sample of phase 0
  task automatic frame(logic [3*NL-1:0] pat, string req);
    for (int p = 0; p < 6; p++) begin
      chk({"R2 R3 ", req}, com, exp_com(p));
      chk({"R4 R5 ", req}, seg, exp_seg(pat, p));
      step(DIV);
    end
  endtask

  initial begin
    // R1: reset state independent of seg_i
    #35;
    chk("R1 com", com, exp_com(0));
    chk("R1 seg", seg, exp_seg('0, 0));
    @(negedge clk);
    rst_n = 1;
    #1;
    // R6: first frame still shows the cleared pattern although seg_i is all ones
    frame('0, "R6 first frame");
    // now at phase 0 of frame 2 with all ones
    frame('1, "R6 loaded");

    // R2: phase lasts exactly DIV cycles
    step(DIV - 1);
    chk("R2 phase len hold", com, exp_com(0));
    step(1);
    chk("R2 phase len next", com, exp_com(1));

    // vector walk
    for (int v = 0; v < NV; v++) begin
      seg_in = PATS[v];
      sync_frame();
      frame(PATS[v], "R5 vector");
    end

    // R6: mid-frame change ignored until boundary
    step(2 * DIV);
    seg_in = 12'h3C6;
    step(0);
    sync_frame();
    frame(12'h3C6, "R6 base");
    step(2 * DIV);
    seg_in = 12'h815;
    step(1);
    chk("R6 midframe com", com, exp_com(2));
    chk("R6 midframe seg", seg, exp_seg(12'h3C6, 2));
    step(DIV - 1);
    chk("R6 midframe p3", seg, exp_seg(12'h3C6, 3));
    step(2 * DIV);
    chk("R6 midframe p5", seg, exp_seg(12'h3C6, 5));
    step(DIV);
    frame(12'h815, "R6 after boundary");

    // R7: shutdown mid-frame
    step(3 * DIV + 1);
    @(negedge clk);
    shut = 1;
    #1;
    chk("R7 com idle", com, 0);
    chk("R7 seg idle", seg, 0);
    seg_in = 12'h6B1;
    step(10);
    chk("R7 com held", com, 0);
    chk("R7 seg held", seg, 0);
    // R8: restart at phase 0 with the latest pattern
    @(negedge clk);
    shut = 0;
    #1;
    frame(12'h6B1, "R8 restart");
    chk("R8 wrap com", com, exp_com(0));

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      summary();
      $finish;
    end
  end
endmodule